// File: doc/BRIEF.md
# Beat-Synchronous Gate Quantizer

This block lines up a free-running gate with a musical grid. A beat clock delivers one pulse per quarter note. From those pulses the block builds a grid of boundaries spaced one, two or four beats apart, chosen by a division select. The quantized gate output changes only at a grid boundary. At each boundary it copies the level that the synchronized input gate has at that moment, the way a D flip-flop clocked by the grid would.

A one-cycle trigger output fires at every boundary where the sampled gate is high. It can drive envelope generators that need a strike rather than a level. Both the gate and the beat input are asynchronous to the system clock, and each passes through a two-stage synchronizer.

Two state machines make up the core. The beat edge tracker has the states EDGE_HIGH (the beat was last seen high) and EDGE_ARMED (the beat was last seen low). The move from EDGE_ARMED to EDGE_HIGH is the rising edge that advances the divider. The output holder has the states OUT_LOW and OUT_HELD. It moves from OUT_LOW to OUT_HELD at a boundary while the gate is high. It moves from OUT_HELD to OUT_LOW at a boundary while the gate is low. In every other cycle it stays where it is.

Top module: `beat_gate_quantizer`

## Requirements
- R1: After the input gate rises, the quantized gate stays low until the next grid boundary and goes high there.
- R2: After the input gate falls, the quantized gate stays high until the next grid boundary and goes low there.
- R3: Grid boundaries fall on every rising beat edge for division code 2'b00 (quarter), on every 2nd for 2'b01 (half), and on every 4th for 2'b10 or 2'b11 (whole). Each count starts from the previous boundary.
- R4: The division select is taken at each boundary. It sets the spacing to the following boundary, so a change between boundaries does not move the boundary already pending.
- R5: At a boundary the quantized gate takes the synchronized input gate level at that instant, and holds that level until the next boundary.
- R6: A gate pulse that rises and falls entirely between two boundaries causes no change on the quantized gate and no trigger.
- R7: Several gate pulses within one grid period produce at most one rising edge of the quantized gate at the next boundary.
- R8: The trigger is high for exactly one system clock cycle at each boundary where the sampled gate is high, and only while the quantized gate is high.
- R9: Reset drives both outputs low, clears the beat divider and selects quarter spacing, so the first rising beat edge after reset is always a boundary.
- R10: The outputs update at the third rising system clock edge after the beat input rises: two synchronizer stages, then the state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_async_i | input | 1 | Input gate, asynchronous |
| beat_async_i | input | 1 | Beat clock, one pulse per quarter note, asynchronous |
| div_sel_i | input | 2 | Grid division: 00 quarter, 01 half, 10/11 whole |
| qgate_o | output | 1 | Quantized gate |
| trig_o | output | 1 | One-cycle trigger at a boundary with the gate high |

## Verification
A vector walk steps through all three divisions and pulses the beat once per step. On each step it first confirms that the output has not followed a new gate level before the beat, which separates deferred behaviour from a plain pass-through. It then confirms that boundaries land exactly every 1, 2 or 4 beats, and that a division change only moves the boundary after the one already pending. Directed patterns cover a short pulse wholly between boundaries, which must vanish, and a burst of pulses that must merge into one output edge. They also cover a reset with the gate held high, which must restart the grid on the first beat. Finally, the beat edge is counted cycle by cycle to pin the three-edge latency and the single-cycle trigger width.

// File: rtl/bgq_pkg.sv
package bgq_pkg;

    // width of the beat divider; whole note spacing needs four counts
    localparam int unsigned CNT_W = 2;

    typedef enum logic [1:0] {
        DIV_QUARTER   = 2'b00,
        DIV_HALF      = 2'b01,
        DIV_WHOLE     = 2'b10,
        DIV_WHOLE_ALT = 2'b11
    } div_e;

    typedef enum logic {
        EDGE_HIGH  = 1'b0,
        EDGE_ARMED = 1'b1
    } edge_state_e;

    typedef enum logic {
        OUT_LOW  = 1'b0,
        OUT_HELD = 1'b1
    } out_state_e;

    // last divider count before a boundary for a given division
    function automatic logic [CNT_W-1:0] last_count(div_e d);
        logic [CNT_W-1:0] r;
        unique case (d)
            DIV_QUARTER:   r = CNT_W'(0);
            DIV_HALF:      r = CNT_W'(1);
            DIV_WHOLE,
            DIV_WHOLE_ALT: r = CNT_W'(3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bgq_sync.sv
module bgq_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[0] <= '0;
                    else         stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q[s] <= '0;
                    else         stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bgq_grid.sv
module bgq_grid
    import bgq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic beat_i,
    input  div_e div_sel_i,
    output logic tick_o
);

    edge_state_e      edge_q, edge_d;
    logic [CNT_W-1:0] cnt_q;
    div_e             act_q;
    logic             beat_rise;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) edge_q <= EDGE_HIGH;
        else         edge_q <= edge_d;
    end

    // next state
    always_comb begin
        edge_d = edge_q;
        unique case (edge_q)
            EDGE_HIGH:  if (!beat_i) edge_d = EDGE_ARMED;
            EDGE_ARMED: if (beat_i)  edge_d = EDGE_HIGH;
        endcase
    end

    // outputs
    always_comb begin
        beat_rise = (edge_q == EDGE_ARMED) && beat_i;
        tick_o    = beat_rise && (cnt_q == last_count(act_q));
    end

    // divider: counts beat edges since the last boundary
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            act_q <= DIV_QUARTER;
        end else if (beat_rise) begin
            if (tick_o) begin
                cnt_q <= '0;
                act_q <= div_sel_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bgq_hold.sv
module bgq_hold
    import bgq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic gate_i,
    output logic qgate_o,
    output logic trig_o
);

    out_state_e st_q, st_d;
    logic       trig_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= OUT_LOW;
        else         st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OUT_LOW:  if (tick_i && gate_i)  st_d = OUT_HELD;
            OUT_HELD: if (tick_i && !gate_i) st_d = OUT_LOW;
        endcase
    end

    // outputs: trigger registered alongside the state update
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trig_q <= 1'b0;
        else         trig_q <= tick_i && gate_i;
    end

    assign qgate_o = (st_q == OUT_HELD);
    assign trig_o  = trig_q;

endmodule

// File: rtl/beat_gate_quantizer.sv
module beat_gate_quantizer
    import bgq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       gate_async_i,
    input  logic       beat_async_i,
    input  logic [1:0] div_sel_i,
    output logic       qgate_o,
    output logic       trig_o
);

    logic [1:0] raw_in;
    logic [1:0] synced;
    logic       gate_s;
    logic       beat_s;
    logic       grid_tick;

    assign raw_in = {beat_async_i, gate_async_i};
    assign gate_s = synced[0];
    assign beat_s = synced[1];

    bgq_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    bgq_grid u_grid (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .beat_i    (beat_s),
        .div_sel_i (div_e'(div_sel_i)),
        .tick_o    (grid_tick)
    );

    bgq_hold u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (grid_tick),
        .gate_i  (gate_s),
        .qgate_o (qgate_o),
        .trig_o  (trig_o)
    );

endmodule

// File: rtl/bgq_checker.sv
module bgq_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic gate_s,
    input logic tick,
    input logic qgate_o,
    input logic trig_o
);

    // R1 and R2: the output moves only after a boundary
    p_hold_between_ticks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> $stable(qgate_o));

    // R5: a high sample sets the output and fires the trigger
    p_sample_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && gate_s) |=> (qgate_o && trig_o));

    // R2: a low sample clears the output
    p_sample_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && !gate_s) |=> (!qgate_o && !trig_o));

    // R8: the trigger lasts one cycle
    p_trig_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);

    // R8: the trigger only accompanies a held output
    p_trig_with_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |-> qgate_o);

    // R9: reset clears both outputs
    p_reset_clear_r9: assert property (@(posedge clk_i)
        !rst_ni |=> (!qgate_o && !trig_o));

endmodule

bind beat_gate_quantizer bgq_checker u_bgq_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .gate_s  (gate_s),
    .tick    (grid_tick),
    .qgate_o (qgate_o),
    .trig_o  (trig_o)
);

// File: tb/test_beat_gate_quantizer.sv
module test_beat_gate_quantizer;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       gate = 1'b0;
    logic       beat = 1'b0;
    logic [1:0] div = 2'b00;
    logic       qgate;
    logic       trig;

    int n_chk = 0;
    int n_fail = 0;
    int trig_cnt = 0;
    int qrise_cnt = 0;
    logic trig_prev = 1'b0;
    logic q_prev = 1'b0;
    logic trig_wide = 1'b0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    beat_gate_quantizer i_beat_gate_quantizer (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .gate_async_i (gate),
        .beat_async_i (beat),
        .div_sel_i    (div),
        .qgate_o      (qgate),
        .trig_o       (trig)
    );

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (trig) trig_cnt++;
        if (trig && trig_prev) trig_wide = 1'b1;
        if (qgate && !q_prev) qrise_cnt++;
        trig_prev = trig;
        q_prev    = qgate;
    end

    // {div[1:0], gate, exp_q, exp_trig, req[3:0]}
    localparam logic [8:0] VEC [0:20] = '{
        {2'b00, 1'b1, 1'b1, 1'b1, 4'd1},
        {2'b00, 1'b1, 1'b1, 1'b1, 4'd8},
        {2'b00, 1'b0, 1'b0, 1'b0, 4'd2},
        {2'b01, 1'b0, 1'b0, 1'b0, 4'd4},
        {2'b01, 1'b1, 1'b0, 1'b0, 4'd3},
        {2'b01, 1'b1, 1'b1, 1'b1, 4'd3},
        {2'b01, 1'b0, 1'b1, 1'b0, 4'd2},
        {2'b01, 1'b0, 1'b0, 1'b0, 4'd3},
        {2'b10, 1'b1, 1'b0, 1'b0, 4'd4},
        {2'b10, 1'b1, 1'b1, 1'b1, 4'd4},
        {2'b10, 1'b0, 1'b1, 1'b0, 4'd3},
        {2'b10, 1'b0, 1'b1, 1'b0, 4'd3},
        {2'b10, 1'b0, 1'b1, 1'b0, 4'd3},
        {2'b10, 1'b0, 1'b0, 1'b0, 4'd3},
        {2'b00, 1'b1, 1'b0, 1'b0, 4'd4},
        {2'b00, 1'b1, 1'b0, 1'b0, 4'd4},
        {2'b00, 1'b1, 1'b0, 1'b0, 4'd4},
        {2'b00, 1'b1, 1'b1, 1'b1, 4'd4},
        {2'b00, 1'b1, 1'b1, 1'b1, 4'd5},
        {2'b11, 1'b1, 1'b1, 1'b1, 4'd3},
        {2'b00, 1'b0, 1'b1, 1'b0, 4'd3}
    };

    function automatic string req_name(logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_beat();
        @(negedge clk) beat = 1'b1;
        cycles(4);
        beat = 1'b0;
        cycles(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        int r0;
        logic prev_q;

        cycles(3);
        chk("R9", qgate, 0);
        chk("R9", trig, 0);
        rst_ni = 1'b1;
        cycles(3);

        // vector walk, one beat per entry
        prev_q = 1'b0;
        for (int i = 0; i < 21; i++) begin
            div  = VEC[i][8:7];
            gate = VEC[i][6];
            cycles(4);
            chk(req_name(VEC[i][3:0]), qgate, prev_q);   // R1/R2: not yet moved
            t0 = trig_cnt;
            pulse_beat();
            chk(req_name(VEC[i][3:0]), qgate, VEC[i][5]);
            chk(req_name(VEC[i][3:0]), trig_cnt - t0, VEC[i][4]);
            prev_q = VEC[i][5];
        end

        // R9: reset with the gate held high
        gate = 1'b1;
        div  = 2'b10;
        @(negedge clk) rst_ni = 1'b0;
        cycles(2);
        chk("R9", qgate, 0);
        chk("R9", trig, 0);
        rst_ni = 1'b1;
        cycles(6);
        chk("R9", qgate, 0);
        t0 = trig_cnt;
        pulse_beat();
        chk("R9", qgate, 1);
        chk("R9", trig_cnt - t0, 1);

        // R10: latency from the beat edge; whole spacing now active
        pulse_beat();
        pulse_beat();
        pulse_beat();
        chk("R10", qgate, 1);
        gate = 1'b0;
        cycles(4);
        t0 = trig_cnt;
        @(negedge clk) beat = 1'b1;
        cycles(2);
        chk("R10", qgate, 1);
        cycles(1);
        chk("R10", qgate, 0);
        cycles(2);
        beat = 1'b0;
        cycles(4);
        chk("R10", trig_cnt - t0, 0);

        // R6: short pulse between boundaries vanishes; quarter chosen for later
        div = 2'b00;
        t0 = trig_cnt;
        r0 = qrise_cnt;
        pulse_beat();
        @(negedge clk) gate = 1'b1;
        cycles(3);
        gate = 1'b0;
        cycles(4);
        pulse_beat();
        pulse_beat();
        pulse_beat();
        chk("R6", qgate, 0);
        chk("R6", qrise_cnt - r0, 0);
        chk("R6", trig_cnt - t0, 0);

        // R7: a burst of pulses merges into one event
        t0 = trig_cnt;
        r0 = qrise_cnt;
        for (int k = 0; k < 3; k++) begin
            gate = 1'b1;
            cycles(3);
            gate = 1'b0;
            cycles(3);
        end
        gate = 1'b1;
        cycles(4);
        chk("R7", qrise_cnt - r0, 0);
        pulse_beat();
        chk("R7", qrise_cnt - r0, 1);
        chk("R7", trig_cnt - t0, 1);

        // R8: no trigger ever lasted two cycles
        chk("R8", int'(trig_wide), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule